// File: doc/BRIEF.md
# Hierarchical Full-Map Directory Entry Controller

This block is the state machine for a single directory entry at one node of a coherence tree. Each child port of the node, called a descendant, leads to one subtree. The entry records which descendants hold the block in a full presence vector. It also holds the block tag, a dirty flag, a transient flag, an invalidation flag and an acknowledgement counter. Descendants send read and write requests. The parent level sends replies and invalidations. The entry forwards misses upward and fans invalidations downward to every marked descendant. It counts the acknowledgements before it settles into a stable state.

The entry has seven states. Each state is defined by its presence vector, dirty, transient and invalidation bits. There are three stable states: empty, shared and owned. Two wait states cover a read or a write that is pending at the parent. A drain state removes sibling copies for a local ownership change. A purge state removes all copies at the parent's command. While the entry is busy, new requests are refused with a NACK and are not queued. Every output is registered, so a response appears in the cycle after the input that caused it.

Top module: `dir_entry_ctrl`

## Requirements
- R1: Synchronous reset puts the entry in the empty state (code 0). Presence vector, dirty, transient, invalidation, counter and tag are zero, and every pulse output is low.
- R2: A request in the empty state has several effects. It loads the tag and sets only the requester's presence bit. It sets dirty equal to the write flag and sets the transient flag. It emits one upward request carrying the write flag. It then enters read-wait (code 4) or write-wait (code 5).
- R3: A parent reply in read-wait moves the entry to shared (code 2). A parent reply in write-wait moves it to owned (code 3). In both cases the transient flag clears and a grant goes to the waiting requester, with the exclusive bit equal to the write flag.
- R4: In shared, a read adds the requester's presence bit and grants at once, with exclusive low. In owned, a request from the owner grants at once with exclusive high, and the state does not change.
- R5: A write in shared goes straight to owned with an exclusive grant when no other descendant is marked. Otherwise it enters drain (code 1) and does four things: it sends an invalidation to every other marked descendant, loads the counter with their number, and clears the presence vector and dirty flag.
- R6: Any request in owned from a descendant that is not the owner enters drain. It sends an invalidation to the owner only and loads the counter with 1.
- R7: In drain, each descendant acknowledgement lowers the counter by one. The last acknowledgement does three things: it moves to owned (for a write) or shared (for a read), sets only the requester's presence bit, and grants to the requester.
- R8: A parent invalidation in shared or owned enters purge (code 6). It sends invalidations to all marked descendants and loads the counter with their number. It clears the presence and dirty bits and sets the transient and invalidation flags. The last acknowledgement returns the entry to empty and sends a done pulse to the parent. A parent invalidation in empty is answered with done at once.
- R9: In read-wait, write-wait, drain and purge, a descendant request gets a NACK and a parent invalidation gets a parent NACK. Neither changes the state, the fields or the counter.
- R10: When a parent invalidation and a descendant request arrive in the same cycle, the invalidation is served and the descendant request gets a NACK.
- R11: An acknowledgement outside drain and purge is ignored, and so is a parent reply outside the two wait states.
- R12: The presence vector is zero in empty, drain and purge, and holds exactly one bit in owned. The transient flag is set only in the two wait states and purge. Dirty is set only in owned and write-wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq_valid | input | 1 | Descendant request present |
| dreq_write | input | 1 | Request is write/modify (1) or read (0) |
| dreq_src | input | IDW | Index of the requesting descendant |
| dreq_tag | input | TAGW | Tag carried by the request, stored on allocation |
| dack_valid | input | 1 | One descendant invalidation acknowledgement |
| prep_valid | input | 1 | Parent reply to the outstanding upward request |
| pinv_valid | input | 1 | Invalidation command from the parent |
| gnt_o | output | 1 | Grant pulse to a descendant |
| gnt_dst_o | output | IDW | Descendant receiving the grant (0 when no grant) |
| gnt_excl_o | output | 1 | Grant carries write permission |
| dnack_o | output | 1 | Descendant request refused |
| up_o | output | 1 | Upward request pulse |
| up_write_o | output | 1 | Upward request is a write |
| dinv_o | output | NDESC | Invalidation mask to descendants (one cycle) |
| pdone_o | output | 1 | Parent invalidation completed |
| pnack_o | output | 1 | Parent invalidation refused |
| state_o | output | 3 | Entry state code |
| pres_o | output | NDESC | Presence vector |
| dirty_o | output | 1 | Dirty flag |
| trans_o | output | 1 | Transient flag |
| invf_o | output | 1 | Invalidation-in-progress flag |
| ackcnt_o | output | CW | Outstanding acknowledgement count |
| tag_o | output | TAGW | Stored tag |

## Verification
The hardest situation to reach is drain. It needs a shared entry with several holders, followed by a write from one of them or a foreign request to an owned line. The stimulus builds sharers one read at a time after a parent reply, then issues the write. Acknowledgements are then fed one per cycle, and a refused request is interleaved in the middle of the count. Purge with three holders uses the same build-up, and the parent-versus-descendant collision is placed on an owned line.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [2:0] {
        S_EMPTY  = 3'd0,
        S_DRAIN  = 3'd1,
        S_SHARED = 3'd2,
        S_OWNED  = 3'd3,
        S_RDWAIT = 3'd4,
        S_WRWAIT = 3'd5,
        S_PURGE  = 3'd6
    } dstate_e;

    typedef struct packed {
        logic gnt;
        logic excl;
        logic nack;
        logic up;
        logic upw;
        logic pdone;
        logic pnack;
    } evt_t;

    function automatic logic is_busy(dstate_e s);
        return (s == S_DRAIN) || (s == S_RDWAIT) || (s == S_WRWAIT) || (s == S_PURGE);
    endfunction

endpackage

// File: rtl/dir_popcnt.sv
module dir_popcnt #(
    parameter int W  = 4,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/dir_onehot.sv
module dir_onehot #(
    parameter int W   = 4,
    parameter int IDW = $clog2(W)
) (
    input  logic [IDW-1:0] idx,
    output logic [W-1:0]   oh
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign oh[g] = (idx == IDW'(g));
    end
endmodule

// File: rtl/dir_entry_ctrl.sv
module dir_entry_ctrl
    import dir_pkg::*;
#(
    parameter int NDESC = 4,
    parameter int TAGW  = 8,
    localparam int IDW  = $clog2(NDESC),
    localparam int CW   = $clog2(NDESC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dreq_valid,
    input  logic             dreq_write,
    input  logic [IDW-1:0]   dreq_src,
    input  logic [TAGW-1:0]  dreq_tag,
    input  logic             dack_valid,
    input  logic             prep_valid,
    input  logic             pinv_valid,
    output logic             gnt_o,
    output logic [IDW-1:0]   gnt_dst_o,
    output logic             gnt_excl_o,
    output logic             dnack_o,
    output logic             up_o,
    output logic             up_write_o,
    output logic [NDESC-1:0] dinv_o,
    output logic             pdone_o,
    output logic             pnack_o,
    output logic [2:0]       state_o,
    output logic [NDESC-1:0] pres_o,
    output logic             dirty_o,
    output logic             trans_o,
    output logic             invf_o,
    output logic [CW-1:0]    ackcnt_o,
    output logic [TAGW-1:0]  tag_o
);

    dstate_e          state_q, state_d;
    logic [NDESC-1:0] pres_q, pres_d;
    logic             dirty_q, dirty_d, trans_q, trans_d, invf_q, invf_d;
    logic [CW-1:0]    ackcnt_q, ackcnt_d;
    logic [TAGW-1:0]  tag_q, tag_d;
    logic [IDW-1:0]   pend_q, pend_d;
    logic             pendw_q, pendw_d;

    evt_t             evt_q, evt_d;
    logic [IDW-1:0]   gdst_q, gdst_d;
    logic [NDESC-1:0] dinv_q, dinv_d;

    logic [NDESC-1:0] src_bit, pend_bit, others;
    logic [CW-1:0]    others_cnt, pres_cnt;

    assign others = pres_q & ~src_bit;

    dir_onehot #(.W(NDESC), .IDW(IDW)) u_src_dec  (.idx(dreq_src), .oh(src_bit));
    dir_onehot #(.W(NDESC), .IDW(IDW)) u_pend_dec (.idx(pend_q),   .oh(pend_bit));
    dir_popcnt #(.W(NDESC), .CW(CW))   u_oth_cnt  (.vec(others),   .cnt(others_cnt));
    dir_popcnt #(.W(NDESC), .CW(CW))   u_pres_cnt (.vec(pres_q),   .cnt(pres_cnt));

    always_comb begin
        state_d  = state_q;
        pres_d   = pres_q;
        dirty_d  = dirty_q;
        trans_d  = trans_q;
        invf_d   = invf_q;
        ackcnt_d = ackcnt_q;
        tag_d    = tag_q;
        pend_d   = pend_q;
        pendw_d  = pendw_q;
        evt_d    = '0;
        gdst_d   = '0;
        dinv_d   = '0;

        if (is_busy(state_q)) begin
            evt_d.nack  = dreq_valid;
            evt_d.pnack = pinv_valid;
            case (state_q)
                S_RDWAIT, S_WRWAIT: begin
                    if (prep_valid) begin
                        state_d   = (state_q == S_WRWAIT) ? S_OWNED : S_SHARED;
                        trans_d   = 1'b0;
                        evt_d.gnt = 1'b1;
                        evt_d.excl = pendw_q;
                        gdst_d    = pend_q;
                    end
                end
                S_DRAIN: begin
                    if (dack_valid) begin
                        if (ackcnt_q == CW'(1)) begin
                            state_d    = pendw_q ? S_OWNED : S_SHARED;
                            pres_d     = pend_bit;
                            dirty_d    = pendw_q;
                            evt_d.gnt  = 1'b1;
                            evt_d.excl = pendw_q;
                            gdst_d     = pend_q;
                        end
                        ackcnt_d = ackcnt_q - CW'(1);
                    end
                end
                default: begin
                    if (dack_valid) begin
                        if (ackcnt_q == CW'(1)) begin
                            state_d     = S_EMPTY;
                            trans_d     = 1'b0;
                            invf_d      = 1'b0;
                            evt_d.pdone = 1'b1;
                        end
                        ackcnt_d = ackcnt_q - CW'(1);
                    end
                end
            endcase
        end else if (pinv_valid) begin
            evt_d.nack = dreq_valid;
            if (state_q == S_EMPTY) begin
                evt_d.pdone = 1'b1;
            end else begin
                state_d  = S_PURGE;
                dinv_d   = pres_q;
                ackcnt_d = pres_cnt;
                pres_d   = '0;
                dirty_d  = 1'b0;
                trans_d  = 1'b1;
                invf_d   = 1'b1;
            end
        end else if (dreq_valid) begin
            case (state_q)
                S_EMPTY: begin
                    state_d   = dreq_write ? S_WRWAIT : S_RDWAIT;
                    pres_d    = src_bit;
                    dirty_d   = dreq_write;
                    trans_d   = 1'b1;
                    tag_d     = dreq_tag;
                    pend_d    = dreq_src;
                    pendw_d   = dreq_write;
                    evt_d.up  = 1'b1;
                    evt_d.upw = dreq_write;
                end
                S_SHARED: begin
                    if (!dreq_write) begin
                        pres_d    = pres_q | src_bit;
                        evt_d.gnt = 1'b1;
                        gdst_d    = dreq_src;
                    end else if (others == '0) begin
                        state_d    = S_OWNED;
                        pres_d     = src_bit;
                        dirty_d    = 1'b1;
                        evt_d.gnt  = 1'b1;
                        evt_d.excl = 1'b1;
                        gdst_d     = dreq_src;
                    end else begin
                        state_d  = S_DRAIN;
                        dinv_d   = others;
                        ackcnt_d = others_cnt;
                        pres_d   = '0;
                        pend_d   = dreq_src;
                        pendw_d  = 1'b1;
                    end
                end
                default: begin
                    if ((pres_q & src_bit) != '0) begin
                        evt_d.gnt  = 1'b1;
                        evt_d.excl = 1'b1;
                        gdst_d     = dreq_src;
                    end else begin
                        state_d  = S_DRAIN;
                        dinv_d   = pres_q;
                        ackcnt_d = pres_cnt;
                        pres_d   = '0;
                        dirty_d  = 1'b0;
                        pend_d   = dreq_src;
                        pendw_d  = dreq_write;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_EMPTY;
            pres_q   <= '0;
            dirty_q  <= 1'b0;
            trans_q  <= 1'b0;
            invf_q   <= 1'b0;
            ackcnt_q <= '0;
            tag_q    <= '0;
            pend_q   <= '0;
            pendw_q  <= 1'b0;
            evt_q    <= '0;
            gdst_q   <= '0;
            dinv_q   <= '0;
        end else begin
            state_q  <= state_d;
            pres_q   <= pres_d;
            dirty_q  <= dirty_d;
            trans_q  <= trans_d;
            invf_q   <= invf_d;
            ackcnt_q <= ackcnt_d;
            tag_q    <= tag_d;
            pend_q   <= pend_d;
            pendw_q  <= pendw_d;
            evt_q    <= evt_d;
            gdst_q   <= gdst_d;
            dinv_q   <= dinv_d;
        end
    end

    assign gnt_o      = evt_q.gnt;
    assign gnt_dst_o  = gdst_q;
    assign gnt_excl_o = evt_q.excl;
    assign dnack_o    = evt_q.nack;
    assign up_o       = evt_q.up;
    assign up_write_o = evt_q.upw;
    assign dinv_o     = dinv_q;
    assign pdone_o    = evt_q.pdone;
    assign pnack_o    = evt_q.pnack;
    assign state_o    = state_q;
    assign pres_o     = pres_q;
    assign dirty_o    = dirty_q;
    assign trans_o    = trans_q;
    assign invf_o     = invf_q;
    assign ackcnt_o   = ackcnt_q;
    assign tag_o      = tag_q;

    // R9: busy entry refuses descendant requests
    p_nack_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (dreq_valid && is_busy(state_q)) |=> dnack_o);

    // R10: parent invalidation wins a same-cycle collision
    p_pinv_prio_r10: assert property (@(posedge clk) disable iff (rst)
        (pinv_valid && dreq_valid) |=> dnack_o);

    // R7: each acknowledgement in drain lowers the counter by one
    p_drain_dec_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DRAIN && dack_valid && ackcnt_q > CW'(1))
        |=> (state_q == S_DRAIN) && (ackcnt_q == CW'($past(ackcnt_q) - CW'(1))));

    // R8: purge loads the counter with the number of holders
    p_purge_load_r8: assert property (@(posedge clk) disable iff (rst)
        ((state_q == S_SHARED || state_q == S_OWNED) && pinv_valid)
        |=> (state_q == S_PURGE) && (ackcnt_q == CW'($countones($past(pres_q)))));

    // R3: parent reply completes a pending read
    p_reply_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RDWAIT && prep_valid) |=> (state_q == S_SHARED) && gnt_o);

    // R12: owned has exactly one holder; empty, drain and purge have none
    p_owned_one_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_OWNED) |-> $onehot(pres_q));
    p_nopres_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EMPTY || state_q == S_DRAIN || state_q == S_PURGE) |-> (pres_q == '0));
    p_trans_r12: assert property (@(posedge clk) disable iff (rst)
        trans_q |-> (state_q == S_RDWAIT || state_q == S_WRWAIT || state_q == S_PURGE));

endmodule

// File: tb/dir_entry_ctrl_test.sv
module dir_entry_ctrl_test;

    localparam int N  = 4;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          dreq_valid = 0, dreq_write = 0, dack_valid = 0, prep_valid = 0, pinv_valid = 0;
    logic [1:0]    dreq_src = 0;
    logic [TW-1:0] dreq_tag = 0;
    logic          gnt_o, gnt_excl_o, dnack_o, up_o, up_write_o, pdone_o, pnack_o;
    logic          dirty_o, trans_o, invf_o;
    logic [1:0]    gnt_dst_o;
    logic [N-1:0]  dinv_o, pres_o;
    logic [2:0]    state_o, ackcnt_o;
    logic [TW-1:0] tag_o;

    dir_entry_ctrl #(.NDESC(N), .TAGW(TW)) uut (
        .clk(clk), .rst(rst),
        .dreq_valid(dreq_valid), .dreq_write(dreq_write), .dreq_src(dreq_src), .dreq_tag(dreq_tag),
        .dack_valid(dack_valid), .prep_valid(prep_valid), .pinv_valid(pinv_valid),
        .gnt_o(gnt_o), .gnt_dst_o(gnt_dst_o), .gnt_excl_o(gnt_excl_o), .dnack_o(dnack_o),
        .up_o(up_o), .up_write_o(up_write_o), .dinv_o(dinv_o), .pdone_o(pdone_o), .pnack_o(pnack_o),
        .state_o(state_o), .pres_o(pres_o), .dirty_o(dirty_o), .trans_o(trans_o), .invf_o(invf_o),
        .ackcnt_o(ackcnt_o), .tag_o(tag_o)
    );

    typedef struct packed {
        logic [2:0]    st;
        logic [N-1:0]  pres;
        logic          dirty, trans, invf;
        logic [2:0]    cnt;
        logic [TW-1:0] tag;
        logic          gnt;
        logic [1:0]    gdst;
        logic          excl, nack, up, upw;
        logic [N-1:0]  dinv;
        logic          pdone, pnack;
    } exp_t;

    exp_t  expq[$];
    string reqq[$];
    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;

    function automatic exp_t mk(input logic [2:0] st, input logic [N-1:0] pres,
                                input logic d, t, i, input logic [2:0] c, input logic [TW-1:0] tg,
                                input logic g, input logic [1:0] gd, input logic ex, nk, u, uw,
                                input logic [N-1:0] dv, input logic pd, pn);
        exp_t e;
        e = '{st, pres, d, t, i, c, tg, g, gd, ex, nk, u, uw, dv, pd, pn};
        return e;
    endfunction

    task automatic cyc(input logic dv, dw, input logic [1:0] src, input logic [TW-1:0] tg,
                       input logic ack, rep, pi, input exp_t e, input string r);
        @(negedge clk);
        dreq_valid = dv; dreq_write = dw; dreq_src = src; dreq_tag = tg;
        dack_valid = ack; prep_valid = rep; pinv_valid = pi;
        expq.push_back(e);
        reqq.push_back(r);
    endtask

    // monitor: compares one cycle after each driven step
    always @(posedge clk) begin
        #1;
        if (expq.size() > 0) begin
            exp_t  e;
            exp_t  a;
            string r;
            e = expq.pop_front();
            r = reqq.pop_front();
            a = '{state_o, pres_o, dirty_o, trans_o, invf_o, ackcnt_o, tag_o, gnt_o, gnt_dst_o,
                  gnt_excl_o, dnack_o, up_o, up_write_o, dinv_o, pdone_o, pnack_o};
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: actual=%h expected=%h", r, a, e);
            end
        end
    end

    initial begin
        #20000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        cyc(0,0,0,0, 0,0,0, mk(0,4'b0000,0,0,0,0,8'h00, 0,0,0,0,0,0,4'b0000,0,0), "R1");
        // R2 read miss from descendant 1
        cyc(1,0,1,8'h5A, 0,0,0, mk(4,4'b0010,0,1,0,0,8'h5A, 0,0,0,0,1,0,4'b0000,0,0), "R2");
        // R9 request while waiting
        cyc(1,0,2,8'h11, 0,0,0, mk(4,4'b0010,0,1,0,0,8'h5A, 0,0,0,1,0,0,4'b0000,0,0), "R9");
        // R3 reply -> shared
        cyc(0,0,0,0, 0,1,0, mk(2,4'b0010,0,0,0,0,8'h5A, 1,1,0,0,0,0,4'b0000,0,0), "R3");
        // R4 sharers added
        cyc(1,0,3,0, 0,0,0, mk(2,4'b1010,0,0,0,0,8'h5A, 1,3,0,0,0,0,4'b0000,0,0), "R4");
        cyc(1,0,0,0, 0,0,0, mk(2,4'b1011,0,0,0,0,8'h5A, 1,0,0,0,0,0,4'b0000,0,0), "R4");
        // R5 write from sharer 3 -> drain two others
        cyc(1,1,3,0, 0,0,0, mk(1,4'b0000,0,0,0,2,8'h5A, 0,0,0,0,0,0,4'b0011,0,0), "R5");
        cyc(0,0,0,0, 1,0,0, mk(1,4'b0000,0,0,0,1,8'h5A, 0,0,0,0,0,0,4'b0000,0,0), "R7");
        cyc(1,0,2,0, 0,0,0, mk(1,4'b0000,0,0,0,1,8'h5A, 0,0,0,1,0,0,4'b0000,0,0), "R9");
        cyc(0,0,0,0, 1,0,0, mk(3,4'b1000,1,0,0,0,8'h5A, 1,3,1,0,0,0,4'b0000,0,0), "R7");
        // R4 owner hit
        cyc(1,1,3,0, 0,0,0, mk(3,4'b1000,1,0,0,0,8'h5A, 1,3,1,0,0,0,4'b0000,0,0), "R4");
        // R6 foreign read in owned
        cyc(1,0,1,0, 0,0,0, mk(1,4'b0000,0,0,0,1,8'h5A, 0,0,0,0,0,0,4'b1000,0,0), "R6");
        cyc(0,0,0,0, 1,0,0, mk(2,4'b0010,0,0,0,0,8'h5A, 1,1,0,0,0,0,4'b0000,0,0), "R7");
        // R5 sole sharer upgrade
        cyc(1,1,1,0, 0,0,0, mk(3,4'b0010,1,0,0,0,8'h5A, 1,1,1,0,0,0,4'b0000,0,0), "R5");
        // R8 parent purge of owned line
        cyc(0,0,0,0, 0,0,1, mk(6,4'b0000,0,1,1,1,8'h5A, 0,0,0,0,0,0,4'b0010,0,0), "R8");
        cyc(0,0,0,0, 0,0,1, mk(6,4'b0000,0,1,1,1,8'h5A, 0,0,0,0,0,0,4'b0000,0,1), "R9");
        cyc(0,0,0,0, 1,0,0, mk(0,4'b0000,0,0,0,0,8'h5A, 0,0,0,0,0,0,4'b0000,1,0), "R8");
        cyc(0,0,0,0, 0,0,1, mk(0,4'b0000,0,0,0,0,8'h5A, 0,0,0,0,0,0,4'b0000,1,0), "R8");
        // R2 write miss
        cyc(1,1,2,8'h3C, 0,0,0, mk(5,4'b0100,1,1,0,0,8'h3C, 0,0,0,0,1,1,4'b0000,0,0), "R2");
        cyc(0,0,0,0, 1,0,0, mk(5,4'b0100,1,1,0,0,8'h3C, 0,0,0,0,0,0,4'b0000,0,0), "R11");
        cyc(0,0,0,0, 0,1,0, mk(3,4'b0100,1,0,0,0,8'h3C, 1,2,1,0,0,0,4'b0000,0,0), "R3");
        cyc(0,0,0,0, 0,1,0, mk(3,4'b0100,1,0,0,0,8'h3C, 0,0,0,0,0,0,4'b0000,0,0), "R11");
        // R10 collision
        cyc(1,0,0,0, 0,0,1, mk(6,4'b0000,0,1,1,1,8'h3C, 0,0,0,1,0,0,4'b0100,0,0), "R10");
        cyc(0,0,0,0, 1,0,0, mk(0,4'b0000,0,0,0,0,8'h3C, 0,0,0,0,0,0,4'b0000,1,0), "R8");
        // three sharers purged
        cyc(1,0,0,8'h77, 0,0,0, mk(4,4'b0001,0,1,0,0,8'h77, 0,0,0,0,1,0,4'b0000,0,0), "R2");
        cyc(0,0,0,0, 0,1,0, mk(2,4'b0001,0,0,0,0,8'h77, 1,0,0,0,0,0,4'b0000,0,0), "R3");
        cyc(1,0,1,0, 0,0,0, mk(2,4'b0011,0,0,0,0,8'h77, 1,1,0,0,0,0,4'b0000,0,0), "R4");
        cyc(1,0,3,0, 0,0,0, mk(2,4'b1011,0,0,0,0,8'h77, 1,3,0,0,0,0,4'b0000,0,0), "R4");
        cyc(0,0,0,0, 0,0,1, mk(6,4'b0000,0,1,1,3,8'h77, 0,0,0,0,0,0,4'b1011,0,0), "R8");
        cyc(0,0,0,0, 1,0,0, mk(6,4'b0000,0,1,1,2,8'h77, 0,0,0,0,0,0,4'b0000,0,0), "R8");
        cyc(0,0,0,0, 1,0,0, mk(6,4'b0000,0,1,1,1,8'h77, 0,0,0,0,0,0,4'b0000,0,0), "R12");
        cyc(0,0,0,0, 1,0,0, mk(0,4'b0000,0,0,0,0,8'h77, 0,0,0,0,0,0,4'b0000,1,0), "R8");
        @(negedge clk);
        dreq_valid = 0; dack_valid = 0; prep_valid = 0; pinv_valid = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule